// File: doc/BRIEF.md
# Iterative Integer Divider Unit

A multi-cycle integer divider that sits beside the execute stage of a small 32-bit core. It produces a quotient and a remainder for signed or unsigned operands, one quotient bit per clock. It uses a restoring shift-and-subtract loop on operand magnitudes and corrects the signs once the loop ends. Both results always come back together in one packed word, whatever operation was asked for. The execute stage picks the half it needs.

The requester raises `start` with the operands, an operation code and a destination-register tag. It then keeps `start` high for as long as `busy` is high. If `start` falls early, for example because an interrupt is taken, the operation is abandoned quietly. On completion `ready` pulses for one cycle and the captured tag is returned on `tag_out`, so the execute stage can write the right register. A zero divisor and the signed overflow case follow the usual integer-division conventions of open 32-bit instruction sets. A zero divisor skips the loop altogether.

Top module: `iter_divider`

## Requirements
- R1: The operation code is 100 for signed quotient, 101 for unsigned quotient, 110 for signed remainder and 111 for unsigned remainder. Bit 0 set to 0 selects signed arithmetic. `result` always holds the quotient in bits [31:0] and the remainder in bits [63:32], for every code.
- R2: For unsigned operation with a nonzero divisor, the quotient is floor(dividend / divisor) and the remainder is dividend minus quotient times divisor.
- R3: For signed operation with a nonzero divisor, the quotient is rounded toward zero and the remainder takes the sign of the dividend.
- R4: With a nonzero divisor, `busy` rises in the cycle after the accepting edge and stays high for exactly 32 cycles. `ready` is high in the following cycle, and `busy` is low in that cycle.
- R5: `ready` is high for one cycle per completed operation.
- R6: With a zero divisor, `busy` never rises. `ready` is high in the cycle after the accepting edge, with quotient 0xFFFFFFFF and remainder equal to the dividend, for signed and unsigned codes alike.
- R7: Signed division of 0x80000000 by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R8: If `start` is low at a clock edge while `busy` is high, `busy` is low in the next cycle, no `ready` follows, and `result` keeps its previous value.
- R9: An operation is accepted only at an edge where the unit is idle, `start` is high and `start` was low at the previous edge. Holding `start` high after completion starts nothing.
- R10: `tag_out` shows the tag captured at acceptance from the next cycle until the next acceptance. Changes to the operand, code and tag inputs after acceptance do not affect the result.
- R11: While `rst_n` is low at a clock edge, `busy`, `ready`, `result` and `tag_out` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request. Its rising edge launches an operation; it must be held high while busy, and dropping it aborts |
| dividend | input | 32 | Dividend, captured at acceptance |
| divisor | input | 32 | Divisor, captured at acceptance |
| op | input | 3 | Operation code (R1) |
| tag_in | input | 5 | Destination-register tag, captured at acceptance |
| busy | output | 1 | Iteration in progress |
| ready | output | 1 | One-cycle completion pulse |
| result | output | 64 | Remainder in [63:32], quotient in [31:0] |
| tag_out | output | 5 | Tag of the accepted operation |

## Verification
The bench builds the unit with its default widths: 32-bit operands, a 5-bit tag and a 3-bit code. At that width the extreme operands are reachable directly: 0x80000000, 0xFFFFFFFF, zero divisors and a divisor of one. The run length is also the real one, so the 32-cycle timing and aborts at the first, a middle and the last iteration are exercised exactly. A 64-bit integer model in the bench predicts `busy`, `ready`, `result` and `tag_out` for every cycle. Meanwhile the driver scrambles the operand, code and tag inputs during each run.

// File: rtl/div_pkg.sv
// Shared definitions for the iterative divider.
// Assumes: operation code bit 0 distinguishes unsigned (1) from signed (0).
package div_pkg;

    // Sequencer state: waiting for a request, or iterating
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    // Position of the unsigned-select bit inside the operation code
    localparam int OP_UNSIGNED_BIT = 0;

endpackage

// File: rtl/div_operand_prep.sv
// Turns raw operands into magnitudes for the unsigned iteration loop.
// It also reports which result signs must be flipped afterwards, and
// whether the divisor is zero.
// Assumes: two's-complement operands; purely combinational.
module div_operand_prep #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    input  logic            is_signed,
    output logic [XLEN-1:0] mag_dvd,
    output logic [XLEN-1:0] mag_dsr,
    output logic            neg_quo,
    output logic            neg_rem,
    output logic            dsr_zero
);
    localparam int MSB = XLEN - 1;

    logic dvd_neg;
    logic dsr_neg;

    // Magnitudes and sign-correction flags
    always_comb begin
        dvd_neg  = is_signed & dividend[MSB];
        dsr_neg  = is_signed & divisor[MSB];
        mag_dvd  = dvd_neg ? ({XLEN{1'b0}} - dividend) : dividend;
        mag_dsr  = dsr_neg ? ({XLEN{1'b0}} - divisor) : divisor;
        neg_quo  = dvd_neg ^ dsr_neg;
        neg_rem  = dvd_neg;
        dsr_zero = (divisor == {XLEN{1'b0}});
    end

endmodule

// File: rtl/div_shift_sub.sv
// Restoring shift-and-subtract datapath: one quotient bit per step.
// The quotient register starts out holding the dividend. Its bits are
// shifted into the partial remainder as quotient bits fill in from the
// right. The next-state values are exported so the caller can finish in
// the same edge as the last step.
// Assumes: divisor magnitude is nonzero while steps are issued.
module div_shift_sub #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [XLEN-1:0] load_dvd,
    input  logic [XLEN-1:0] load_dsr,
    output logic [XLEN-1:0] nxt_quo,
    output logic [XLEN-1:0] nxt_rem
);
    logic [XLEN-1:0] quo_q;
    logic [XLEN-1:0] rem_q;
    logic [XLEN-1:0] dsr_q;
    logic [XLEN:0]   shifted;
    logic [XLEN:0]   trial;
    logic            fits;

    // One trial subtraction and the restore decision
    always_comb begin
        shifted = {rem_q, quo_q[XLEN-1]};
        trial   = shifted - {1'b0, dsr_q};
        fits    = ~trial[XLEN];
        nxt_rem = fits ? trial[XLEN-1:0] : shifted[XLEN-1:0];
        nxt_quo = {quo_q[XLEN-2:0], fits};
    end

    // Working registers: loaded on acceptance, advanced on each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dsr_q <= '0;
        end else if (load) begin
            quo_q <= load_dvd;
            rem_q <= '0;
            dsr_q <= load_dsr;
        end else if (step) begin
            quo_q <= nxt_quo;
            rem_q <= nxt_rem;
        end
    end

endmodule

// File: rtl/div_result_fix.sv
// Applies the sign corrections to the unsigned quotient and remainder.
// Assumes: flags were captured from the same operands as the magnitudes.
module div_result_fix #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] quo_mag,
    input  logic [XLEN-1:0] rem_mag,
    input  logic            neg_quo,
    input  logic            neg_rem,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem
);
    // Conditional two's-complement negation of each result
    always_comb begin
        quo = neg_quo ? ({XLEN{1'b0}} - quo_mag) : quo_mag;
        rem = neg_rem ? ({XLEN{1'b0}} - rem_mag) : rem_mag;
    end

endmodule

// File: rtl/div_ctrl.sv
// Sequencer. It accepts a request on a rising start while idle, runs XLEN
// steps while start stays high, and abandons the run if start falls.
// Assumes: the caller handles the zero-divisor shortcut via dsr_zero.
module div_ctrl
    import div_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dsr_zero,
    output logic accept,
    output logic step,
    output logic finish,
    output logic busy
);
    localparam int              CNT_W    = $clog2(XLEN);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(XLEN - 1);

    div_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start_d;

    // Handshake decode from the current state and start history
    always_comb begin
        busy   = (state_q == ST_RUN);
        accept = !busy && start && !start_d;
        step   = busy && start;
        finish = step && (cnt_q == LAST_IDX);
    end

    // State, step counter and start history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            start_d <= 1'b0;
        end else begin
            start_d <= start;
            if (accept) begin
                cnt_q   <= '0;
                state_q <= dsr_zero ? ST_IDLE : ST_RUN;
            end else if (busy && !start) begin
                state_q <= ST_IDLE;
            end else if (finish) begin
                state_q <= ST_IDLE;
            end else if (step) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/iter_divider.sv
// Iterative integer divider top. It captures operands and the tag on
// acceptance, runs the shift-subtract loop, and registers the packed
// {remainder, quotient} result with a one-cycle ready pulse.
// Assumes: the requester holds start high while busy; dropping it aborts.
module iter_divider
    import div_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int TAG_W = 5,
    parameter int OP_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [XLEN-1:0]   dividend,
    input  logic [XLEN-1:0]   divisor,
    input  logic [OP_W-1:0]   op,
    input  logic [TAG_W-1:0]  tag_in,
    output logic              busy,
    output logic              ready,
    output logic [2*XLEN-1:0] result,
    output logic [TAG_W-1:0]  tag_out
);
    logic              is_signed;
    logic              op_unused_bits;
    logic [XLEN-1:0]   mag_dvd;
    logic [XLEN-1:0]   mag_dsr;
    logic              neg_quo;
    logic              neg_rem;
    logic              dsr_zero;
    logic              accept;
    logic              step;
    logic              finish;
    logic [XLEN-1:0]   nxt_quo;
    logic [XLEN-1:0]   nxt_rem;
    logic [XLEN-1:0]   fix_quo;
    logic [XLEN-1:0]   fix_rem;
    logic              neg_quo_q;
    logic              neg_rem_q;
    logic              ready_q;
    logic [2*XLEN-1:0] result_q;
    logic [TAG_W-1:0]  tag_q;

    // Only the signedness bit changes the arithmetic
    assign is_signed      = ~op[OP_UNSIGNED_BIT];
    assign op_unused_bits = ^op;

    div_operand_prep #(.XLEN(XLEN)) u_prep (
        .dividend  (dividend),
        .divisor   (divisor),
        .is_signed (is_signed),
        .mag_dvd   (mag_dvd),
        .mag_dsr   (mag_dsr),
        .neg_quo   (neg_quo),
        .neg_rem   (neg_rem),
        .dsr_zero  (dsr_zero)
    );

    div_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dsr_zero (dsr_zero),
        .accept   (accept),
        .step     (step),
        .finish   (finish),
        .busy     (busy)
    );

    div_shift_sub #(.XLEN(XLEN)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (step),
        .load_dvd (mag_dvd),
        .load_dsr (mag_dsr),
        .nxt_quo  (nxt_quo),
        .nxt_rem  (nxt_rem)
    );

    div_result_fix #(.XLEN(XLEN)) u_fix (
        .quo_mag (nxt_quo),
        .rem_mag (nxt_rem),
        .neg_quo (neg_quo_q),
        .neg_rem (neg_rem_q),
        .quo     (fix_quo),
        .rem     (fix_rem)
    );

    // Request capture: sign flags and tag held for the whole run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            tag_q     <= '0;
        end else if (accept) begin
            neg_quo_q <= neg_quo;
            neg_rem_q <= neg_rem;
            tag_q     <= tag_in;
        end
    end

    // Result register and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q  <= 1'b0;
            result_q <= '0;
        end else begin
            ready_q <= (accept && dsr_zero) || finish;
            if (accept && dsr_zero) begin
                result_q <= {dividend, {XLEN{1'b1}}};
            end else if (finish) begin
                result_q <= {fix_rem, fix_quo};
            end
        end
    end

    assign ready   = ready_q;
    assign result  = result_q;
    assign tag_out = tag_q;

endmodule

// File: rtl/iter_divider_chk.sv
// Protocol checker for iter_divider, attached by bind.
// It watches only the ports, plus a local start history and a run-length
// counter.
module iter_divider_chk #(
    parameter int XLEN  = 32,
    parameter int TAG_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [XLEN-1:0]   divisor,
    input logic              busy,
    input logic              ready,
    input logic [2*XLEN-1:0] result,
    input logic [TAG_W-1:0]  tag_out
);
    localparam int RC_W = $clog2(XLEN) + 2;

    logic [RC_W-1:0] run_cnt;
    logic            start_seen;

    // Count consecutive busy cycles and remember start from the last edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt    <= '0;
            start_seen <= 1'b0;
        end else begin
            run_cnt    <= busy ? run_cnt + 1'b1 : '0;
            start_seen <= start;
        end
    end

    // R4
    busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && ready));

    // R4
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && $past(busy) |-> run_cnt == RC_W'(XLEN));

    // R5
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R6
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && !start_seen && divisor == '0 |=> ready && !busy);

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !start |=> !busy && !ready);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> $stable(result));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && start_seen |=> !busy && !ready);

    // R10
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(tag_out));

endmodule

bind iter_divider iter_divider_chk #(.XLEN(XLEN), .TAG_W(TAG_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .divisor (divisor),
    .busy    (busy),
    .ready   (ready),
    .result  (result),
    .tag_out (tag_out)
);

// File: tb/iter_divider_tb.sv
`timescale 1ns/1ps
module iter_divider_tb;
    localparam int XLEN  = 32;
    localparam int TAG_W = 5;
    localparam int OP_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [XLEN-1:0]   dividend = '0;
    logic [XLEN-1:0]   divisor = '0;
    logic [OP_W-1:0]   op = '0;
    logic [TAG_W-1:0]  tag_in = '0;
    logic              busy;
    logic              ready;
    logic [2*XLEN-1:0] result;
    logic [TAG_W-1:0]  tag_out;

    iter_divider #(.XLEN(XLEN), .TAG_W(TAG_W), .OP_W(OP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .op(op), .tag_in(tag_in), .busy(busy),
        .ready(ready), .result(result), .tag_out(tag_out)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R11";
    bit    done = 1'b0;

    // Behavioural model state
    bit          m_busy = 0, m_ready = 0, m_prev = 0, m_sg = 0;
    int          m_cnt = 0;
    logic [63:0] m_res = '0;
    logic [4:0]  m_tag = '0;
    logic [31:0] m_a = '0, m_b = '0;

    function automatic logic [63:0] ref_div(input logic [31:0] a, input logic [31:0] b, input bit sg);
        longint sa, sb, q, r;
        if (b == 32'h0) return {a, 32'hFFFF_FFFF};
        if (sg) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
        end else begin
            sa = longint'({32'h0, a});
            sb = longint'({32'h0, b});
        end
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
    endfunction

    task automatic model_step();
        if (!rst_n) begin
            m_busy = 0; m_ready = 0; m_prev = 0; m_cnt = 0; m_res = '0; m_tag = '0;
            return;
        end
        m_ready = 0;
        if (m_busy) begin
            if (!start) m_busy = 0;
            else begin
                m_cnt++;
                if (m_cnt == XLEN) begin
                    m_busy = 0; m_ready = 1; m_res = ref_div(m_a, m_b, m_sg);
                end
            end
        end else if (start && !m_prev) begin
            m_a = dividend; m_b = divisor; m_sg = !op[0]; m_tag = tag_in;
            if (divisor == 32'h0) begin
                m_ready = 1; m_res = ref_div(m_a, m_b, m_sg);
            end else begin
                m_busy = 1; m_cnt = 0;
            end
        end
        m_prev = start;
    endtask

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({63'h0, busy}, {63'h0, m_busy}, "busy");
        chk({63'h0, ready}, {63'h0, m_ready}, "ready");
        chk(result, m_res, "result");
        chk({59'h0, tag_out}, {59'h0, m_tag}, "tag_out");
    endtask

    // Launch one request; scramble inputs after acceptance; optional abort and hold
    task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                          input logic [4:0] t, input int abort_at, input int hold_after);
        op = o; dividend = a; divisor = b; tag_in = t; start = 1'b1;
        for (int i = 0; i < 40; i++) begin
            tick();
            dividend = dividend ^ 32'h5A5A_1234;
            divisor  = (i % 3 == 0) ? 32'h0 : divisor + 32'd3;
            tag_in   = tag_in + 5'd1;
            op       = op ^ 3'b001;
            if (abort_at > 0 && i + 1 == abort_at) begin
                start = 1'b0;
                break;
            end
            if (m_ready) break;
        end
        repeat (hold_after) tick();
        start = 1'b0;
        tick();
        tick();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        cur_req = "R11";
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        cur_req = "R2 R4 R5";
        run_op(3'b101, 32'd100, 32'd7, 5'd3, 0, 0);
        run_op(3'b101, 32'hFFFF_FFFF, 32'h10, 5'd9, 0, 0);
        run_op(3'b111, 32'd5, 32'd9, 5'd1, 0, 0);
        run_op(3'b101, 32'h8000_0000, 32'hFFFF_FFFF, 5'd2, 0, 0);

        cur_req = "R3";
        run_op(3'b100, 32'hFFFF_FFF9, 32'd2, 5'd4, 0, 0);
        run_op(3'b100, 32'd7, 32'hFFFF_FFFE, 5'd5, 0, 0);
        run_op(3'b110, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 5'd6, 0, 0);

        cur_req = "R1";
        run_op(3'b110, 32'd1000, 32'd33, 5'd7, 0, 0);
        run_op(3'b111, 32'hDEAD_BEEF, 32'd1, 5'd8, 0, 0);

        cur_req = "R6";
        run_op(3'b100, 32'h1234_5678, 32'h0, 5'd10, 0, 0);
        run_op(3'b111, 32'h8765_4321, 32'h0, 5'd11, 0, 0);

        cur_req = "R7";
        run_op(3'b100, 32'h8000_0000, 32'hFFFF_FFFF, 5'd12, 0, 0);

        cur_req = "R8";
        run_op(3'b101, 32'd999, 32'd10, 5'd13, 1, 0);
        run_op(3'b100, 32'd999, 32'd10, 5'd14, 17, 0);
        run_op(3'b110, 32'd999, 32'd10, 5'd15, 32, 0);
        run_op(3'b101, 32'd81, 32'd9, 5'd16, 0, 0);

        cur_req = "R9";
        run_op(3'b101, 32'd64, 32'd8, 5'd17, 0, 6);
        run_op(3'b100, 32'd64, 32'h0, 5'd18, 0, 4);

        cur_req = "R10";
        run_op(3'b100, 32'hFFFF_0000, 32'd3, 5'd31, 0, 0);
        run_op(3'b101, 32'd0, 32'd12345, 5'd0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule